// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits between a set of interrupt request sources and a CPU. Each source can raise a request that stays pending until it is taken or withdrawn. Each source has a 2-bit priority code and a per-source mask, and one global enable gates every source. Every cycle the controller picks one candidate from the pending, unmasked sources. The candidate is the source with the highest priority level. When several sources share that level, the one with the lowest index (its vector number) wins. The controller presents the winner to the CPU on registered outputs.

The controller keeps track of the level of the handler that is currently running. A candidate is offered only if its level is strictly above that running level. Requests at an equal or lower level therefore wait, while a request at a higher level can pre-empt the running handler and nest inside it. When the CPU acknowledges, the controller clears the winner's pending flag and pushes the old running level onto a small stack. The running level then rises to the winner's level. When the CPU signals a return from interrupt, the controller pops the stack and restores the previous level. Requests that were held off are then evaluated again on the next cycle.

Top module: `nested_irq_prio`

## Requirements
- R1: After a synchronous reset, `irq_valid` is 0, `run_level` is 0 (no handler running) and no source is pending.
- R2: A 1 on `req_set[i]` makes source i pending at the next clock edge. If source i is eligible, `irq_valid` rises one edge later and `irq_vector` equals i.
- R3: Priority code c of source i is `prio_code[2*i+1:2*i]`. Code 0 maps to level 1 (low), code 1 to level 2 (high), and codes 2 and 3 to level 3 (highest). `irq_level` reports this level for the offered vector.
- R4: Among eligible pending sources, the one with the highest level is offered.
- R5: Among eligible pending sources at the same level, the lowest index is offered.
- R6: A source whose `src_mask` bit is 1 is not offered, and while `glob_en` is 0 no source is offered. In both cases the request stays pending and is offered once it is unmasked or enabled again.
- R7: A pending source is offered only if its level is strictly greater than `run_level`. A source at a higher level is offered while a handler is running, which lets handlers nest.
- R8: When `cpu_ack` is 1 and `irq_valid` is 1, the offered source's pending flag is cleared and `run_level` takes `irq_level` at the next edge. `irq_valid` is 0 after that edge.
- R9: When `cpu_reti` is 1 and there is no acknowledge in the same cycle, `run_level` returns at the next edge to the level that was running before the most recent acknowledge. A `cpu_reti` with no handler running has no effect.
- R10: A 1 on `req_clr[i]` withdraws a pending request of source i. If `req_set[i]` is also 1 in the same cycle, the set wins.
- R11: `cpu_ack` has no effect while `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NUM_SRC | Per-source request pulse, makes the source pending |
| req_clr | input | NUM_SRC | Per-source withdraw pulse |
| src_mask | input | NUM_SRC | Per-source mask, 1 blocks the source |
| glob_en | input | 1 | Global enable for all sources |
| prio_code | input | 2*NUM_SRC | 2-bit priority code per source |
| cpu_ack | input | 1 | CPU takes the offered vector |
| cpu_reti | input | 1 | CPU returns from the running handler |
| irq_valid | output | 1 | A vector is being offered |
| irq_vector | output | $clog2(NUM_SRC) | Offered vector number |
| irq_level | output | 2 | Level (1..3) of the offered vector |
| run_level | output | 2 | Level of the running handler, 0 when idle |

## Verification
The bench builds the block with 16 sources and a three-entry level stack. With 16 sources, same-level ties can be set up among widely spaced indices, all three levels can be pending at once, and nesting can reach the full three-deep stack. A fixed-seed random phase mixes sets, withdrawals, mask changes and acknowledge and return pulses. Directed sequences cover the return with an empty stack and the case where set and withdraw arrive in the same cycle.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;

  // priority code to running level: 0->1, 1->2, 2/3->3
  function automatic lvl_t code_to_lvl(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/nirq_pend_bank.sv
module nirq_pend_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] take_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= set_i | (pend_q & ~(clr_i | take_i));
  end

  assign pend_o = pend_q;

  // R10: a set in the same cycle as a withdraw leaves the source pending
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R8: a taken source without a new set is no longer pending
  p_take_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ((take_i & ~set_i) != '0) |=> ((pend_o & $past(take_i & ~set_i)) == '0));
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]   pend_i,
  input  logic [NUM_SRC-1:0]   mask_i,
  input  logic                 en_i,
  input  logic [2*NUM_SRC-1:0] prio_i,
  input  lvl_t                 cur_i,
  output logic                 found_o,
  output logic [IDW-1:0]       vec_o,
  output lvl_t                 lvl_o
);
  logic [NUM_SRC-1:0] elig;
  lvl_t               src_lvl [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_lvl[g] = code_to_lvl(prio_i[2*g +: 2]);
    assign elig[g]    = en_i && pend_i[g] && !mask_i[g] && (src_lvl[g] > cur_i);
  end

  // descending scan with >= : highest level wins, lowest index breaks ties
  always_comb begin
    found_o = 1'b0;
    vec_o   = '0;
    lvl_o   = LVL_IDLE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (src_lvl[i] >= lvl_o)) begin
        found_o = 1'b1;
        vec_o   = IDW'(i);
        lvl_o   = src_lvl[i];
      end
    end
  end

  // R7: any selection lies strictly above the running level
  always_comb begin
    p_above_running_r7: assert (!found_o || (lvl_o > cur_i));
  end
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack
  import nirq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t push_lvl_i,
  output lvl_t top_o,
  output logic empty_o
);
  lvl_t           mem [DEPTH];
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (push_i && (sp_q < SPW'(DEPTH))) mem[sp_q[$clog2(DEPTH)-1:0]] <= push_lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                        sp_q <= '0;
    else if (push_i)                sp_q <= sp_q + 1'b1;
    else if (pop_i && sp_q != '0)   sp_q <= sp_q - 1'b1;
  end

  assign empty_o = (sp_q == '0);
  assign top_o   = empty_o ? LVL_IDLE : mem[$clog2(DEPTH)'(sp_q - 1'b1)];

  // R7: strict nesting can never push more levels than exist
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (sp_q < SPW'(DEPTH)));
endmodule

// File: rtl/nested_irq_prio.sv
module nested_irq_prio
  import nirq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int STACK_DEPTH = 3,
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   req_set,
  input  logic [NUM_SRC-1:0]   req_clr,
  input  logic [NUM_SRC-1:0]   src_mask,
  input  logic                 glob_en,
  input  logic [2*NUM_SRC-1:0] prio_code,
  input  logic                 cpu_ack,
  input  logic                 cpu_reti,
  output logic                 irq_valid,
  output logic [IDW-1:0]       irq_vector,
  output logic [1:0]           irq_level,
  output logic [1:0]           run_level
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] take;
  logic               arb_found;
  logic [IDW-1:0]     arb_vec;
  lvl_t               arb_lvl;
  lvl_t               cur_q;
  lvl_t               stk_top;
  logic               stk_empty;
  logic               valid_q;
  logic [IDW-1:0]     vec_q;
  lvl_t               lvl_q;
  logic               ack_ok;
  logic               pop_ok;

  assign ack_ok = cpu_ack && valid_q;
  assign pop_ok = cpu_reti && !ack_ok && !stk_empty;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_take
    assign take[g] = ack_ok && (vec_q == IDW'(g));
  end

  nirq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(req_set), .clr_i(req_clr),
    .take_i(take), .pend_o(pend)
  );

  nirq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i(pend), .mask_i(src_mask), .en_i(glob_en), .prio_i(prio_code),
    .cur_i(cur_q), .found_o(arb_found), .vec_o(arb_vec), .lvl_o(arb_lvl)
  );

  nirq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(ack_ok), .pop_i(pop_ok),
    .push_lvl_i(cur_q), .top_o(stk_top), .empty_o(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= LVL_IDLE;
      valid_q <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= LVL_IDLE;
    end else begin
      vec_q <= arb_vec;
      lvl_q <= arb_lvl;
      if (ack_ok) begin
        cur_q   <= lvl_q;
        valid_q <= 1'b0;
      end else begin
        if (pop_ok) cur_q <= stk_top;
        valid_q <= arb_found;
      end
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
  assign irq_level  = lvl_q;
  assign run_level  = cur_q;

  // R7: an offered vector always outranks the running handler
  p_offer_strict_r7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_level > run_level));

  // R8: acknowledge raises the running level and withdraws the offer
  p_ack_level_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_valid) |=> (run_level == $past(irq_level) && !irq_valid));

  // R9: a return always lowers the running level
  p_reti_lower_r9: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (run_level < $past(run_level)));

  // R11: acknowledge without an offer leaves the running level alone
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && !irq_valid && !cpu_reti) |=> $stable(run_level));
endmodule

// File: tb/tb_nested_irq_prio.sv
module tb_nested_irq_prio;
  localparam int N   = 16;
  localparam int IDW = $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst;
  logic [N-1:0]   req_set, req_clr, src_mask;
  logic           glob_en;
  logic [2*N-1:0] prio_code;
  logic           cpu_ack, cpu_reti;
  logic           irq_valid;
  logic [IDW-1:0] irq_vector;
  logic [1:0]     irq_level, run_level;

  nested_irq_prio #(.NUM_SRC(N), .STACK_DEPTH(3)) dut (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
    .src_mask(src_mask), .glob_en(glob_en), .prio_code(prio_code),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .run_level(run_level)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  bit [N-1:0] m_pend;
  int m_cur, m_sp;
  int m_stk [3];
  bit m_valid;
  int m_vec, m_lvl;

  function automatic int code_lvl(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 3;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int bl = 0;
    int bv = 0;
    bit f = 0;
    bit ack_ok;
    for (int i = N - 1; i >= 0; i--) begin
      int l = code_lvl(prio_code[2*i +: 2]);
      if (m_pend[i] && !src_mask[i] && glob_en && l > m_cur && l >= bl) begin
        bl = l; bv = i; f = 1;
      end
    end
    ack_ok = cpu_ack && m_valid;
    for (int i = 0; i < N; i++) begin
      if (req_set[i]) m_pend[i] = 1'b1;
      else if (req_clr[i] || (ack_ok && i == m_vec)) m_pend[i] = 1'b0;
    end
    if (ack_ok) begin
      m_stk[m_sp] = m_cur; m_sp++; m_cur = m_lvl; m_valid = 0;
    end else begin
      if (cpu_reti && m_sp > 0) begin m_sp--; m_cur = m_stk[m_sp]; end
      m_valid = f;
    end
    m_vec = bv; m_lvl = bl;
  endtask

  task automatic compare_model(input string req);
    chk(req, "irq_valid", int'(irq_valid), int'(m_valid));
    chk(req, "run_level", int'(run_level), m_cur);
    if (m_valid) begin
      chk(req, "irq_vector", int'(irq_vector), m_vec);
      chk(req, "irq_level", int'(irq_level), m_lvl);
    end
  endtask

  task automatic cycle(input string req);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_model(req);
    req_set = '0; req_clr = '0; cpu_ack = 0; cpu_reti = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; req_set = '0; req_clr = '0; src_mask = '0; glob_en = 1;
    prio_code = '0; cpu_ack = 0; cpu_reti = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_pend = '0; m_cur = 0; m_sp = 0; m_valid = 0; m_vec = 0; m_lvl = 0;
    chk("R1", "irq_valid after reset", int'(irq_valid), 0);
    chk("R1", "run_level after reset", int'(run_level), 0);
    cycle("R1");
    chk("R1", "nothing pending", int'(irq_valid), 0);

    // tie at high level between 3 and 9, lower source 12
    prio_code[2*3 +: 2] = 2'd1; prio_code[2*9 +: 2] = 2'd1; prio_code[2*12 +: 2] = 2'd0;
    req_set = (N'(1) << 3) | (N'(1) << 9) | (N'(1) << 12);
    cycle("R2");
    cycle("R5");
    chk("R5", "tie vector", int'(irq_vector), 3);
    chk("R3", "code1 level", int'(irq_level), 2);

    prio_code[2*7 +: 2] = 2'd3; req_set = N'(1) << 7;
    cycle("R2");
    cycle("R4");
    chk("R4", "highest wins vector", int'(irq_vector), 7);
    chk("R3", "code3 level", int'(irq_level), 3);

    cpu_ack = 1;
    cycle("R8");
    chk("R8", "run_level after ack", int'(run_level), 3);
    chk("R8", "valid after ack", int'(irq_valid), 0);
    cycle("R7");
    chk("R7", "lower held off", int'(irq_valid), 0);

    cpu_reti = 1;
    cycle("R9");
    chk("R9", "restored level", int'(run_level), 0);
    cycle("R9");
    chk("R9", "held request offered", int'(irq_vector), 3);
    cpu_reti = 1;
    cycle("R9");
    chk("R9", "reti with empty stack", int'(run_level), 0);

    src_mask[3] = 1;
    cycle("R6");
    chk("R6", "masked skipped", int'(irq_vector), 9);
    glob_en = 0;
    cycle("R6");
    chk("R6", "global disable", int'(irq_valid), 0);
    cpu_ack = 1;
    cycle("R11");
    chk("R11", "ack without offer", int'(run_level), 0);
    glob_en = 1; src_mask = '0;
    cycle("R6");
    chk("R6", "request kept pending", int'(irq_vector), 3);

    cpu_ack = 1;
    cycle("R8");
    chk("R8", "run_level high", int'(run_level), 2);
    prio_code[2*14 +: 2] = 2'd2; req_set = N'(1) << 14;
    cycle("R7");
    cycle("R7");
    chk("R7", "nested highest", int'(irq_vector), 14);
    cpu_ack = 1;
    cycle("R7");
    chk("R7", "nested level", int'(run_level), 3);
    cpu_reti = 1;
    cycle("R9");
    chk("R9", "pop to high", int'(run_level), 2);
    cpu_reti = 1;
    cycle("R9");
    chk("R9", "pop to idle", int'(run_level), 0);

    req_set = N'(1) << 9; req_clr = (N'(1) << 9) | (N'(1) << 12);
    cycle("R10");
    src_mask = ~(N'(1) << 12);
    cycle("R10");
    cycle("R10");
    chk("R10", "withdrawn source", int'(irq_valid), 0);
    src_mask = ~(N'(1) << 9);
    cycle("R10");
    chk("R10", "set beats withdraw", int'(irq_vector), 9);
    src_mask = '0;

    for (int n = 0; n < 4000; n++) begin
      req_set = N'($urandom & $urandom & $urandom);
      req_clr = N'($urandom & $urandom & $urandom & $urandom);
      if ($urandom % 16 == 0) src_mask = N'($urandom & $urandom);
      if ($urandom % 32 == 0) prio_code = 32'($urandom);
      glob_en = ($urandom % 10) != 0;
      cpu_ack = m_valid && ($urandom % 3 == 0);
      cpu_reti = ($urandom % 5 == 0);
      cycle("R4 R5 R7 R8 R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule